// File: doc/BRIEF.md
# Programmable Output Macrocell Bank

This block is a bank of output cells for a small programmable logic array. Each cell receives a sum term from the array. It can send that term straight to its pin, or capture it in a D flip-flop and drive the stored bit. An invert bit can flip the pin level after the storage point. Because of this, clearing or setting the flip-flop always stores the same bit, whatever the polarity. The pin's output enable comes from one of three sources: held on, held off, or a per-cell enable term from the array. Each cell returns a feedback bit to the array in true and complement form. In registered mode that bit is the stored state. In combinational mode it is the level actually present on the pin. A cell whose enable is held off therefore works as a plain input.

Two terms are shared by the whole bank. The first clears every flip-flop at once, asynchronously. The second sets every flip-flop at the next rising clock edge. A power-up reset clears all storage. A test preload path loads any chosen pattern into the flip-flops on the next edge, including states the normal logic would never reach. Each pin is modelled as a drive value, a drive enable and a separately supplied external level. All pins are plain level signals. There is no stream and no back-pressure, because every result is either combinational or one register stage deep.

Top module: `macrocell_bank`

## Requirements
- R1: With `cfg_registered[i]`=1, the stored bit of cell i takes `sum_term[i]` on each rising clock edge. Between edges, `pin_dout[i]` does not follow changes on `sum_term[i]`.
- R2: With `cfg_registered[i]`=0, `pin_dout[i]` follows `sum_term[i]` in the same cycle, with no clock edge needed.
- R3: `cfg_invert[i]`=1 makes `pin_dout[i]` the complement of the cell's value in both modes. In registered mode the stored bit, and so `fb_true[i]`, is unchanged by the invert bit.
- R4: `ar_term`=1 clears every flip-flop at once without a clock edge. It wins over preload, preset and D at any edge. The pin then shows `cfg_invert[i]`.
- R5: `sp_term`=1, with `ar_term` and `test_mode` both 0, loads 1 into every flip-flop at the next rising edge, whatever `sum_term` is.
- R6: `cfg_oe_sel[2i+1:2i]` picks the enable of cell i: 00 = off, 01 = on, 10 = follow `oe_term[i]`, 11 = off.
- R7: In registered mode, `fb_true[i]` is the stored bit and `fb_comp[i]` is its complement. `pin_in[i]` has no effect on either, even when the pin is not driven.
- R8: In combinational mode, `fb_true[i]` is the pin level and `fb_comp[i]` is its complement. The pin level is `pin_dout[i]` when `pin_oe[i]`=1 and `pin_in[i]` otherwise.
- R9: While `rst_n` is 0, every flip-flop holds 0, so a registered cell drives `pin_dout[i]` = `cfg_invert[i]`.
- R10: `test_mode`=1 with `ar_term`=0 loads `preload_val` into the flip-flops at the next rising edge. This wins over `sp_term` and `sum_term`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| sum_term | input | W | Sum term per cell from the array |
| oe_term | input | W | Enable product term per cell |
| ar_term | input | 1 | Shared asynchronous clear term |
| sp_term | input | 1 | Shared synchronous set term |
| cfg_registered | input | W | 1 = registered mode, 0 = combinational |
| cfg_invert | input | W | 1 = inverted pin polarity |
| cfg_oe_sel | input | 2*W | Enable source code per cell |
| test_mode | input | 1 | Preload enable |
| preload_val | input | W | Pattern loaded while test_mode is 1 |
| pin_in | input | W | Level driven onto the pin from outside |
| pin_dout | output | W | Pin drive value |
| pin_oe | output | W | Pin drive enable |
| fb_true | output | W | Feedback to the array, true form |
| fb_comp | output | W | Feedback to the array, complement form |

## Verification
The shared clear, the shared set, the test preload and the normal D capture can all act on the same rising edge. The bench provokes each overlap on purpose. Preload is raised together with the set term while `sum_term` differs from both, and the captured pattern must equal `preload_val`. The clear term is held across an edge while the set term is high and `sum_term` is all ones, and the stored state must stay zero. Each of these is judged at the pins a half cycle after the edge, under a non-zero invert mask. That mask shows that polarity changes the pin level but not the stored state.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int OE_SEL_W = 2;

  typedef enum logic [OE_SEL_W-1:0] {
    OE_OFF  = 2'b00,
    OE_ON   = 2'b01,
    OE_TERM = 2'b10,
    OE_RSVD = 2'b11
  } oe_sel_e;
endpackage

// File: rtl/mc_state_reg.sv
module mc_state_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ar_term,
  input  logic         sp_term,
  input  logic         test_mode,
  input  logic [W-1:0] preload_val,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  // clear > preload > set > D
  always_ff @(posedge clk or negedge rst_n or posedge ar_term) begin
    if (!rst_n || ar_term) q <= '0;
    else if (test_mode)    q <= preload_val;
    else if (sp_term)      q <= ALL_ONES;
    else                   q <= d_in;
  end

  assert_clear_now_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ar_term |-> (q == '0));

  assert_set_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_term && !test_mode && !ar_term) |=> (ar_term || q == ALL_ONES));

  assert_preload_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !ar_term) |=> (ar_term || q == $past(preload_val)));

  assert_powerup_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q == '0));
endmodule

// File: rtl/mc_pin_ctrl.sv
module mc_pin_ctrl
  import mc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]          q,
  input  logic [W-1:0]          sum_term,
  input  logic [W-1:0]          cfg_registered,
  input  logic [W-1:0]          cfg_invert,
  input  logic [OE_SEL_W*W-1:0] cfg_oe_sel,
  input  logic [W-1:0]          oe_term,
  output logic [W-1:0]          pin_dout,
  output logic [W-1:0]          pin_oe
);
  for (genvar g = 0; g < W; g++) begin : g_cell
    oe_sel_e sel;
    logic    cell_val;

    assign sel      = oe_sel_e'(cfg_oe_sel[g*OE_SEL_W +: OE_SEL_W]);
    assign cell_val = cfg_registered[g] ? q[g] : sum_term[g];
    // polarity applied after the storage point
    assign pin_dout[g] = cell_val ^ cfg_invert[g];

    always_comb begin
      case (sel)
        OE_ON:   pin_oe[g] = 1'b1;
        OE_TERM: pin_oe[g] = oe_term[g];
        default: pin_oe[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mc_feedback.sv
module mc_feedback #(
  parameter int W = 4
) (
  input  logic [W-1:0] q,
  input  logic [W-1:0] cfg_registered,
  input  logic [W-1:0] pin_dout,
  input  logic [W-1:0] pin_oe,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] fb_true,
  output logic [W-1:0] fb_comp
);
  logic [W-1:0] pin_level;

  for (genvar g = 0; g < W; g++) begin : g_cell
    assign pin_level[g] = pin_oe[g] ? pin_dout[g] : pin_in[g];
    assign fb_true[g]   = cfg_registered[g] ? q[g] : pin_level[g];
  end

  assign fb_comp = ~fb_true;
endmodule

// File: rtl/macrocell_bank.sv
module macrocell_bank
  import mc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [W-1:0]          sum_term,
  input  logic [W-1:0]          oe_term,
  input  logic                  ar_term,
  input  logic                  sp_term,
  input  logic [W-1:0]          cfg_registered,
  input  logic [W-1:0]          cfg_invert,
  input  logic [OE_SEL_W*W-1:0] cfg_oe_sel,
  input  logic                  test_mode,
  input  logic [W-1:0]          preload_val,
  input  logic [W-1:0]          pin_in,
  output logic [W-1:0]          pin_dout,
  output logic [W-1:0]          pin_oe,
  output logic [W-1:0]          fb_true,
  output logic [W-1:0]          fb_comp
);
  logic [W-1:0] state_q;

  mc_state_reg #(.W(W)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .ar_term     (ar_term),
    .sp_term     (sp_term),
    .test_mode   (test_mode),
    .preload_val (preload_val),
    .d_in        (sum_term),
    .q           (state_q)
  );

  mc_pin_ctrl #(.W(W)) u_pin (
    .q              (state_q),
    .sum_term       (sum_term),
    .cfg_registered (cfg_registered),
    .cfg_invert     (cfg_invert),
    .cfg_oe_sel     (cfg_oe_sel),
    .oe_term        (oe_term),
    .pin_dout       (pin_dout),
    .pin_oe         (pin_oe)
  );

  mc_feedback #(.W(W)) u_fb (
    .q              (state_q),
    .cfg_registered (cfg_registered),
    .pin_dout       (pin_dout),
    .pin_oe         (pin_oe),
    .pin_in         (pin_in),
    .fb_true        (fb_true),
    .fb_comp        (fb_comp)
  );

  for (genvar g = 0; g < W; g++) begin : g_chk
    // pin driver and feedback path must agree on the stored bit
    assert_reg_polarity_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_registered[g] |-> (pin_dout[g] == (fb_true[g] ^ cfg_invert[g])));

    assert_comb_fb_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_registered[g] && pin_oe[g]) |-> (fb_true[g] == pin_dout[g]));
  end
endmodule

// File: tb/test_macrocell_bank.sv
`timescale 1ns/1ps
module test_macrocell_bank;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] sum_term, oe_term, cfg_registered, cfg_invert, preload_val, pin_in;
  logic [2*W-1:0] cfg_oe_sel;
  logic         ar_term, sp_term, test_mode;
  logic [W-1:0] pin_dout, pin_oe, fb_true, fb_comp;

  always #10 clk = ~clk;  // 50 MHz

  macrocell_bank #(.W(W)) i_macrocell_bank (
    .clk(clk), .rst_n(rst_n), .sum_term(sum_term), .oe_term(oe_term),
    .ar_term(ar_term), .sp_term(sp_term), .cfg_registered(cfg_registered),
    .cfg_invert(cfg_invert), .cfg_oe_sel(cfg_oe_sel), .test_mode(test_mode),
    .preload_val(preload_val), .pin_in(pin_in), .pin_dout(pin_dout),
    .pin_oe(pin_oe), .fb_true(fb_true), .fb_comp(fb_comp)
  );

  typedef struct {
    string        tag;
    logic [W-1:0] dout;
    logic [W-1:0] oe;
    logic [W-1:0] fbt;
  } exp_t;

  exp_t sb_q[$];
  exp_t cur;
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  task automatic push(input string tag, input logic [W-1:0] d,
                      input logic [W-1:0] o, input logic [W-1:0] f);
    exp_t e;
    e.tag = tag; e.dout = d; e.oe = o; e.fbt = f;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // monitor: compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        cur = sb_q.pop_front();
        n_run++;
        if (pin_dout !== cur.dout || pin_oe !== cur.oe ||
            fb_true !== cur.fbt || fb_comp !== ~cur.fbt) begin
          n_fail++;
          $display("FAIL %s: dout=%b oe=%b fbt=%b fbc=%b expected dout=%b oe=%b fbt=%b fbc=%b",
                   cur.tag, pin_dout, pin_oe, fb_true, fb_comp,
                   cur.dout, cur.oe, cur.fbt, ~cur.fbt);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sum_term = '0; oe_term = '0; ar_term = 1'b0; sp_term = 1'b0;
    cfg_registered = 4'b1111; cfg_invert = 4'b1010; cfg_oe_sel = 8'b01010101;
    test_mode = 1'b0; preload_val = '0; pin_in = '0;

    // R9: reset state, pin shows invert bit
    step(); push("R9", 4'b1010, 4'b1111, 4'b0000);
    step(); rst_n = 1'b1;

    // R1: capture only at edges
    step(); cfg_invert = 4'b0000; sum_term = 4'b0110;
    push("R1", 4'b0000, 4'b1111, 4'b0000);
    step(); push("R1", 4'b0110, 4'b1111, 4'b0110);
    step(); sum_term = 4'b1001;
    push("R1", 4'b0110, 4'b1111, 4'b0110);
    step(); push("R1", 4'b1001, 4'b1111, 4'b1001);

    // R3: polarity after register, stored state unchanged
    step(); cfg_invert = 4'b1100;
    push("R3", 4'b0101, 4'b1111, 4'b1001);

    // R5: set term overrides D
    step(); sp_term = 1'b1; sum_term = 4'b0000;
    step(); push("R5", 4'b0011, 4'b1111, 4'b1111);
    sp_term = 1'b0; sum_term = 4'b1111;

    // R4: asynchronous clear, then held over an edge against set
    step(); ar_term = 1'b1;
    push("R4", 4'b1100, 4'b1111, 4'b0000);
    sp_term = 1'b1;
    step(); push("R4", 4'b1100, 4'b1111, 4'b0000);
    ar_term = 1'b0; sp_term = 1'b0;

    // R10: preload beats set and D
    step(); test_mode = 1'b1; preload_val = 4'b1010; sp_term = 1'b1; sum_term = 4'b0101;
    step(); push("R10", 4'b0110, 4'b1111, 4'b1010);
    test_mode = 1'b0; sp_term = 1'b0;

    // R2: combinational follows sum term at once
    step(); cfg_registered = 4'b0000; cfg_invert = 4'b0000; sum_term = 4'b0011;
    push("R2", 4'b0011, 4'b1111, 4'b0011);
    step(); cfg_invert = 4'b0101;
    push("R3", 4'b0110, 4'b1111, 4'b0110);

    // R6: enable select codes 00 off, 01 on, 10 term, 11 off
    step(); cfg_invert = 4'b0000; sum_term = 4'b1111;
    cfg_oe_sel = 8'b11100100; oe_term = 4'b0100;
    push("R6", 4'b1111, 4'b0110, 4'b0110);
    step(); oe_term = 4'b0000;
    push("R6", 4'b1111, 4'b0010, 4'b0010);

    // R8: undriven combinational pins feed back the external level
    step(); pin_in = 4'b1001;
    push("R8", 4'b1111, 4'b0010, 4'b1011);

    // R7: registered feedback ignores the pin
    step(); cfg_registered = 4'b1111; cfg_oe_sel = 8'b00000000;
    sum_term = 4'b0101; pin_in = 4'b1010;
    step(); push("R7", 4'b0101, 4'b0000, 4'b0101);
    step(); pin_in = 4'b0000;
    push("R7", 4'b0101, 4'b0000, 4'b0101);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule